// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial half of an SPI master. It pulls words from a show-ahead transmit FIFO and shifts each one out as a frame of 4, 8 or 16 bits. At the same time it samples the incoming line and hands each completed frame to a receive FIFO as a one-cycle push. Static control inputs set the frame size, the clock phase and polarity, and the bit order. They also set how the select line behaves between frames, how long select leads the first clock, and whether the transfer sends, receives or does both. An even divider input sets the serial clock rate.

A burst begins when the engine is enabled and the transmit FIFO holds data. Each frame takes exactly one FIFO entry. When a frame finishes and the FIFO is empty, or enable has been dropped, select is released and the engine returns to idle.

Top module: `spi_frame_engine`

## Requirements
- R1: `frame_size` picks the frame length: 00 gives 4 bits, 01 gives 8 bits and 10 gives 16 bits, using the low bits of `tx_data`. The code 11 is invalid, and no transfer starts while it is applied.
- R2: When `cpha`=0, the first data bit is valid before the first clock edge, and data is sampled on leading edges. When `cpha`=1, data changes on leading edges and is sampled on trailing edges.
- R3: `sclk` rests at the `cpol` level whenever `cs_n` is high: low for 0, high for 1.
- R4: `cs_mode` 00 holds `cs_n` low between back-to-back frames. Mode 01 raises it for half a serial period between frames, and mode 10 for a full serial period; after that gap, select and the setup delay are applied again. Mode 11 is invalid, and no transfer starts.
- R5: Let H be half a serial period. From `cs_n` falling to the first `sclk` edge there are d·H system clocks with `cpha`=1 and (d+1)·H with `cpha`=0. d is 1 when `cs_delay`=0 and 2 when `cs_delay`=1.
- R6: `lsb_first`=0 shifts the most significant frame bit first and `lsb_first`=1 the least significant, for both `mosi` and `miso`.
- R7: `xfer_mode` 00 sends and receives. Mode 01 only sends, and `rx_push` never pulses. Mode 10 only receives, and `mosi` stays 0. Mode 11 is invalid, and no transfer starts.
- R8: The serial period is `clk_div` system clocks, so H = `clk_div`/2. A `clk_div` that is odd or below 2 is invalid, and no transfer starts.
- R9: A burst starts only when `enable` is high and `tx_empty` is low. `tx_pop` pulses once per frame, consuming `tx_data` in that cycle. If `enable` falls during a frame, that frame completes, select is released and the remaining entries stay queued.
- R10: After reset `cs_n`=1 and `busy`=0. `busy` is high from select assertion until select release, including the gaps between frames.
- R11: Each received frame gives one single-cycle `rx_push`, with the frame in the low bits of `rx_data` and zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows bursts to start and continue |
| frame_size | input | 2 | Frame length code |
| cpha | input | 1 | Clock phase |
| cpol | input | 1 | Clock idle level |
| lsb_first | input | 1 | Bit order select |
| cs_mode | input | 2 | Select behaviour between frames |
| cs_delay | input | 1 | Select-to-clock setup delay |
| xfer_mode | input | 2 | Send/receive direction |
| clk_div | input | DIV_W | System clocks per serial period |
| tx_data | input | 16 | Head of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Consume head of transmit FIFO |
| rx_data | output | 16 | Received frame |
| rx_push | output | 1 | Write `rx_data` to receive FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| busy | output | 1 | Burst in progress |

## Verification
A slave model answers on the serial pins with its own words and reassembles what it samples. It is driven through all four phase/polarity pairs, and this separates a wrong sampling edge from a wrong idle level. Runs with each frame size, each bit order and each direction mode tell apart a truncated frame, a reversed frame, a missing push and a stray push. Bursts under each select mode, at several dividers and both setup delays, are timed edge by edge to separate gap length from setup delay and half period. Reserved codes, odd dividers, enable held low and enable dropped mid-burst show whether a transfer starts or stops when it should.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       frame_size,
  input  logic             cpha,
  input  logic             cpol,
  input  logic             lsb_first,
  input  logic [1:0]       cs_mode,
  input  logic             cs_delay,
  input  logic [1:0]       xfer_mode,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [15:0]      tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic [15:0]      rx_data,
  output logic             rx_push,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             busy
);
  localparam int HW = DIV_W - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_GAP} state_t;

  state_t         st;
  logic [HW-1:0]  cnt;
  logic [4:0]     ph;
  logic [15:0]    txw, rxw, rx_q;
  logic           rxp_q;

  logic [HW-1:0]  half;
  logic           tick, cfg_ok, more, start, last_ph, frame_end;
  logic [3:0]     top_bit, bidx, pos;

  assign half    = clk_div[DIV_W-1:1];
  assign tick    = (cnt == half - 1'b1);
  assign cfg_ok  = (frame_size != 2'b11) && (cs_mode != 2'b11) &&
                   (xfer_mode != 2'b11) && (half != '0) && !clk_div[0];
  assign top_bit = (frame_size == 2'b00) ? 4'd3 :
                   (frame_size == 2'b01) ? 4'd7 : 4'd15;
  assign bidx    = ph[4:1];
  assign pos     = lsb_first ? bidx : top_bit - bidx;
  assign last_ph = (ph == {top_bit, 1'b1});
  assign more    = enable && !tx_empty;
  assign start   = (st == ST_IDLE) && more && cfg_ok;
  assign frame_end = (st == ST_XFER) && tick && last_ph;
  assign tx_pop  = start || (frame_end && more);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      ph    <= '0;
      txw   <= '0;
      rxw   <= '0;
      rx_q  <= '0;
      rxp_q <= 1'b0;
    end else begin
      rxp_q <= 1'b0;
      cnt   <= (st == ST_IDLE || tick) ? '0 : cnt + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          txw <= tx_data;
          rxw <= '0;
          ph  <= '0;
          st  <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          if (ph[0] == cs_delay) begin
            ph <= '0;
            st <= ST_XFER;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_XFER: if (tick) begin
          if (!ph[0]) rxw[pos] <= miso;
          if (last_ph) begin
            ph <= '0;
            if (xfer_mode != 2'b01) begin
              rxp_q <= 1'b1;
              rx_q  <= rxw;
            end
            if (more) begin
              txw <= tx_data;
              rxw <= '0;
              st  <= (cs_mode == 2'b00) ? ST_XFER : ST_GAP;
            end else begin
              st  <= ST_IDLE;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (ph[0] == cs_mode[1]) begin
            ph <= '0;
            st <= ST_LEAD;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cs_n    = !(st == ST_LEAD || st == ST_XFER);
  assign busy    = (st != ST_IDLE);
  assign sclk    = cpol ^ ((st == ST_XFER) && (ph[0] ^ cpha));
  assign mosi    = !cs_n && (xfer_mode != 2'b10) && txw[pos];
  assign rx_data = rx_q;
  assign rx_push = rxp_q;
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] frame_size,
  input logic       cpol,
  input logic [1:0] cs_mode,
  input logic [1:0] xfer_mode,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic       busy
);
  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (sclk == cpol)); // R3
  AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy); // R10
  AST_TXONLY_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (xfer_mode == 2'b01) |-> !rx_push); // R7
  AST_RXONLY_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n) (xfer_mode == 2'b10) |-> !mosi); // R7
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> (!tx_empty && enable)); // R9
  AST_BAD_SIZE_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && frame_size == 2'b11) |=> !busy); // R1
  AST_BAD_SEL_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cs_mode == 2'b11) |=> !busy); // R4
  AST_HOLD_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (cs_mode == 2'b00 && !cs_n) |=> (!cs_n || !busy)); // R4
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> !rx_push); // R11
endmodule

bind spi_frame_engine spi_frame_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .frame_size(frame_size),
  .cpol(cpol), .cs_mode(cs_mode), .xfer_mode(xfer_mode), .tx_empty(tx_empty),
  .tx_pop(tx_pop), .rx_push(rx_push), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n), .busy(busy)
);

// File: tb/test_spi_frame_engine.sv
`timescale 1ns/1ps
module test_spi_frame_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic enable = 1'b0, cpha = 1'b0, cpol = 1'b0, lsb_first = 1'b0, cs_delay = 1'b0;
  logic [1:0] frame_size = 2'b01, cs_mode = 2'b00, xfer_mode = 2'b00;
  logic [7:0] clk_div = 8'd4;
  logic [15:0] tx_data = 16'h0;
  logic tx_empty = 1'b1;
  logic miso = 1'b0;
  logic tx_pop, rx_push, sclk, mosi, cs_n, busy;
  logic [15:0] rx_data;

  spi_frame_engine #(.DIV_W(8)) i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_size(frame_size),
    .cpha(cpha), .cpol(cpol), .lsb_first(lsb_first), .cs_mode(cs_mode),
    .cs_delay(cs_delay), .xfer_mode(xfer_mode), .clk_div(clk_div),
    .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  int checks = 0, errors = 0, cyc = 0, pops = 0;
  logic [15:0] txq[$], exp_mosi[$], exp_rx[$], sw[$];

  function automatic int nb();
    return (frame_size == 2'b00) ? 4 : (frame_size == 2'b01) ? 8 : 16;
  endfunction
  function automatic int bpos(int i);
    return lsb_first ? i : nb() - 1 - i;
  endfunction
  function automatic logic [15:0] msk();
    return 16'((32'd1 << nb()) - 1);
  endfunction
  function automatic int lead_exp();
    return ((cs_delay ? 2 : 1) + (cpha ? 0 : 1)) * (int'(clk_div) / 2);
  endfunction
  function automatic int gap_exp();
    return ((cs_mode == 2'b10) ? 2 : 1) * (int'(clk_div) / 2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transmit FIFO model
  logic pop_flag = 1'b0;
  always @(posedge clk) pop_flag <= tx_pop;
  always @(negedge clk) begin
    if (pop_flag && txq.size() > 0) begin
      void'(txq.pop_front());
      pops++;
    end
    tx_empty = (txq.size() == 0);
    tx_data  = tx_empty ? 16'h0 : txq[0];
  end

  // slave model and transmitted-frame monitor
  logic scs = 1'b1, ssc = 1'b0;
  int scnt = 0, sidx = 0;
  logic [15:0] sacc = 16'h0;
  function automatic logic sbit(int i);
    return (sidx < sw.size()) ? sw[sidx][bpos(i)] : 1'b0;
  endfunction
  always @(sclk or cs_n) begin
    if (cs_n !== scs) begin
      scs = cs_n;
      if (!cs_n) begin
        scnt = 0;
        sacc = 16'h0;
        miso = sbit(0);
      end
    end else if (sclk !== ssc && !cs_n && rst_n) begin
      if (sclk == (cpol ^ ~cpha)) begin
        if (scnt < nb()) begin
          sacc[bpos(scnt)] = mosi;
          scnt++;
          if (scnt == nb()) begin
            sidx++;
            if (exp_mosi.size() == 0)
              chk(0, "R9 frame with no queued word", int'(sacc), 0);
            else begin
              logic [15:0] e;
              e = exp_mosi.pop_front();
              chk(sacc == e, "R1 R2 R6 R7 transmitted frame", int'(sacc), int'(e));
            end
          end
        end
      end else begin
        if (scnt == nb()) begin
          scnt = 0;
          sacc = 16'h0;
          miso = sbit(0);
        end else if (scnt > 0) begin
          miso = sbit(scnt);
        end
      end
    end
    ssc = sclk;
  end

  // receive scoreboard and select/clock timing monitor
  logic pcs = 1'b1, psclk = 1'b0, first = 1'b0;
  int lastev = 0, hi_run = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_push) begin
        if (exp_rx.size() == 0)
          chk(0, "R7 push with nothing expected", int'(rx_data), 0);
        else begin
          logic [15:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R11 R2 R6 received frame", int'(rx_data), int'(e));
        end
      end
      if (pcs && !cs_n) begin
        if (hi_run > 0) chk(hi_run == gap_exp(), "R4 select gap length", hi_run, gap_exp());
        hi_run = 0;
        lastev = cyc;
        first = 1'b1;
      end
      if (!cs_n && sclk != psclk) begin
        if (first) chk(cyc - lastev == lead_exp(), "R5 select to first clock", cyc - lastev, lead_exp());
        else       chk(cyc - lastev == int'(clk_div) / 2, "R8 half period", cyc - lastev, int'(clk_div) / 2);
        lastev = cyc;
        first = 1'b0;
      end
      if (cs_n && busy) begin
        hi_run++;
        if (cs_mode == 2'b00) chk(0, "R4 select raised in hold mode", 1, 0);
      end
      if (cs_n && !busy && sclk != cpol) chk(0, "R3 idle clock level", int'(sclk), int'(cpol));
    end
    pcs = cs_n;
    psclk = sclk;
  end

  task automatic setcfg(input logic [1:0] fs, input logic ph, input logic po, input logic lsb,
                        input logic [1:0] csm, input logic dly, input logic [1:0] xm, input logic [7:0] dv);
    @(posedge clk); #1;
    frame_size = fs; cpha = ph; cpol = po; lsb_first = lsb;
    cs_mode = csm; cs_delay = dly; xfer_mode = xm; clk_div = dv;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w, s;
      w = 16'($urandom);
      s = 16'($urandom);
      sw.push_back(s);
      exp_mosi.push_back((xfer_mode == 2'b10) ? 16'h0 : (w & msk()));
      if (xfer_mode != 2'b01) exp_rx.push_back(s & msk());
      @(posedge clk); #1;
      txq.push_back(w);
    end
  endtask

  task automatic wait_idle(input string tag);
    do @(negedge clk); while (!(txq.size() == 0 && !busy));
    repeat (4) @(negedge clk);
    chk(exp_mosi.size() == 0, {tag, " R1 all frames shifted"}, exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, {tag, " R11 all frames received"}, exp_rx.size(), 0);
    chk(cs_n && sclk == cpol, {tag, " R3 R10 released to idle"}, int'({cs_n, sclk}), int'({1'b1, cpol}));
  endtask

  task automatic bad_cfg(input string req);
    int p0;
    p0 = pops;
    @(posedge clk); #1;
    txq.push_back(16'h5a5a);
    repeat (40) @(negedge clk);
    chk(!busy && txq.size() == 1 && pops == p0, req, int'(busy), 0);
    @(posedge clk); #1;
    txq.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 reset select", int'(cs_n), 1);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(sclk == cpol, "R3 reset clock level", int'(sclk), int'(cpol));
    chk(!tx_pop && !rx_push, "R9 R11 reset strobes", int'({tx_pop, rx_push}), 0);

    enable = 1'b1;
    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 8'd4);
    send(4); wait_idle("mode0 8b msb hold");

    setcfg(2'b10, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 2'b00, 8'd6);
    send(3); wait_idle("mode3 16b lsb halfgap");

    setcfg(2'b00, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b01, 8'd2);
    send(3); wait_idle("mode2 4b txonly fullgap");

    setcfg(2'b01, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 2'b10, 8'd8);
    send(3); wait_idle("mode1 8b rxonly hold");

    setcfg(2'b10, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 2'b00, 8'd4);
    send(1); wait_idle("single frame");
    send(1); wait_idle("second single frame");

    setcfg(2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 8'd4);
    bad_cfg("R1 reserved frame size");
    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 8'd4);
    bad_cfg("R4 reserved select mode");
    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b11, 8'd4);
    bad_cfg("R7 reserved transfer mode");
    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 8'd5);
    bad_cfg("R8 odd divider");
    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 8'd0);
    bad_cfg("R8 zero divider");

    setcfg(2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 8'd4);
    @(posedge clk); #1 enable = 1'b0;
    send(3);
    repeat (30) @(negedge clk);
    chk(!busy && txq.size() == 3, "R9 enable low holds start", txq.size(), 3);
    @(posedge clk); #1 enable = 1'b1;
    do @(negedge clk); while (!busy);
    @(posedge clk); #1 enable = 1'b0;
    do @(negedge clk); while (busy);
    chk(txq.size() == 2, "R9 enable drop ends after one frame", txq.size(), 2);
    repeat (4) @(negedge clk);
    chk(exp_mosi.size() == 2, "R9 one frame sent before stop", exp_mosi.size(), 2);
    @(posedge clk); #1 enable = 1'b1;
    wait_idle("resume after enable drop");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule